// File: doc/BRIEF.md
# Single-Error-Correcting Memory Word Codec with Partial Double-Error Detection

This block protects a 16-bit dynamic memory word with five check bits, giving a 21-bit stored word. The write side is purely combinational: a data word comes in and its full codeword goes out to the memory array. The read side takes a 21-bit word fetched from the array and forms a 5-bit syndrome. It repairs any single flipped bit and returns the repaired data together with two status flags. An optional register stage, loaded under a clock enable, can sit on the read outputs.

The code uses no extra overall parity bit. A 5-bit syndrome has 32 values. Value zero means a clean word. Values 1 to 21 name the position to invert. The ten values 22 to 31 cannot come from any single-bit error, so they are reported as uncorrectable. One wide OR of the ten syndrome decode lines raises this flag. It catches the share of double errors whose two positions XOR to a value above 21. The remaining double errors look like single errors and are mis-corrected, but still fewer of them than a plain Hamming decoder of the same size would pass.

Top module: `ecc_codec`

## Requirements
- R1: In `wr_code`, bit index p-1 holds codeword position p (1..21). Check bits occupy positions 1, 2, 4, 8 and 16. Data bits `wr_data[0]`..`wr_data[15]` fill positions 3, 5, 6, 7, 9..15 and 17..21 in ascending order.
- R2: Check bit i (at position 2^i) makes the XOR of every position whose index has bit i set equal to zero. An encoded word therefore reads back with syndrome 0.
- R3: A read word with syndrome 0 returns its data bits unchanged, with both flags low.
- R4: A read word with exactly one flipped bit, at any of the 21 positions, returns the original data, with `rd_corrected` high and `rd_uncorrectable` low.
- R5: A syndrome of 22..31 raises `rd_uncorrectable`, keeps `rd_corrected` low and returns the data bits of the read word with no bit inverted.
- R6: `rd_corrected` and `rd_uncorrectable` are never high together.
- R7: Every one of the 210 double errors gives a nonzero syndrome, so it is never reported clean. Each pair is either flagged uncorrectable or mis-corrected as the position equal to the XOR of the two positions.
- R8: With the register stage present (`PIPE_STAGE`=1), the read outputs follow `rd_code` one clock after a rising edge with `rd_en` high. They hold their value while `rd_en` is low, and reset clears all three to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional read register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 16 | Data word to encode |
| wr_code | output | 21 | Encoded word for the memory array |
| rd_en | input | 1 | Load enable of the read register stage |
| rd_code | input | 21 | Word read back from the memory array |
| rd_data | output | 16 | Repaired data word |
| rd_corrected | output | 1 | A single-bit error was repaired |
| rd_uncorrectable | output | 1 | Syndrome points past the last position |

## Verification
On every clock, the assertions check three things: the two flags are exclusive, a zero syndrome leaves the word untouched, and an out-of-range syndrome flips nothing. They also check that a repair inverts exactly one bit and that the register stage holds while its enable is low. Only the bench's scenarios can show that repairs land on the right bit for every position. They are also the only way to confirm the encoder's bit layout and parity and to sort all 210 double errors into detected and mis-corrected. The bench reports the detected fraction.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W   = 16;
  localparam int CHK_W    = 5;
  localparam int CODE_W   = DATA_W + CHK_W;
  localparam int SYN_SPAN = 1 << CHK_W;

  // a position (1-based) is a check slot when it is a power of two
  function automatic bit is_chk_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // 1-based codeword position of data bit k
  function automatic int data_pos(input int k);
    int seen;
    int res;
    seen = 0;
    res  = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_chk_pos(p)) begin
        if (seen == k) res = p;
        seen++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW-1:0]    data_i,
  output logic [DW+CW-1:0] code_o
);
  localparam int NW = DW + CW;

  logic [NW-1:0] placed;

  always_comb begin
    placed = '0;
    for (int k = 0; k < DW; k++) begin
      placed[data_pos(k)-1] = data_i[k];
    end
  end

  always_comb begin
    logic par;
    code_o = placed;
    for (int i = 0; i < CW; i++) begin
      par = 1'b0;
      for (int p = 1; p <= NW; p++) begin
        if (((p >> i) & 1) == 1) par = par ^ placed[p-1];
      end
      code_o[(1 << i) - 1] = par;
    end
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW+CW-1:0] code_i,
  output logic [CW-1:0]    syn_o
);
  localparam int NW = DW + CW;

  always_comb begin
    syn_o = '0;
    for (int i = 0; i < CW; i++) begin
      for (int p = 1; p <= NW; p++) begin
        if (((p >> i) & 1) == 1) syn_o[i] = syn_o[i] ^ code_i[p-1];
      end
    end
  end
endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
  import ecc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHK_W
) (
  input  logic [DW+CW-1:0] code_i,
  input  logic [CW-1:0]    syn_i,
  output logic [DW+CW-1:0] fixed_o,
  output logic [DW-1:0]    data_o,
  output logic             corr_o,
  output logic             uncorr_o
);
  localparam int NW   = DW + CW;
  localparam int SPAN = 1 << CW;
  localparam int NBAD = SPAN - 1 - NW;

  logic [SPAN-1:0] hit;

  for (genvar g = 0; g < SPAN; g++) begin : g_dec
    assign hit[g] = (syn_i == CW'(g));
  end

  if (NBAD > 0) begin : g_bad
    // wide NAND over inverted decode lines of the unused syndromes
    assign uncorr_o = ~&(~hit[SPAN-1:NW+1]);
  end else begin : g_nobad
    assign uncorr_o = 1'b0;
  end

  assign corr_o  = |hit[NW:1];
  assign fixed_o = code_i ^ hit[NW:1];

  always_comb begin
    for (int k = 0; k < DW; k++) begin
      data_o[k] = fixed_o[data_pos(k)-1];
    end
  end
endmodule

// File: rtl/ecc_codec.sv
module ecc_codec
  import ecc_pkg::*;
#(
  parameter int DW         = DATA_W,
  parameter int CW         = CHK_W,
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    wr_data,
  output logic [DW+CW-1:0] wr_code,
  input  logic             rd_en,
  input  logic [DW+CW-1:0] rd_code,
  output logic [DW-1:0]    rd_data,
  output logic             rd_corrected,
  output logic             rd_uncorrectable
);
  localparam int NW = DW + CW;

  logic [CW-1:0] syn_w;
  logic [NW-1:0] fixed_w;
  logic [DW-1:0] dat_w;
  logic          corr_w;
  logic          unc_w;

  ecc_encoder #(.DW(DW), .CW(CW)) u_enc (
    .data_i (wr_data),
    .code_o (wr_code)
  );

  ecc_syndrome #(.DW(DW), .CW(CW)) u_syn (
    .code_i (rd_code),
    .syn_o  (syn_w)
  );

  ecc_corrector #(.DW(DW), .CW(CW)) u_cor (
    .code_i   (rd_code),
    .syn_i    (syn_w),
    .fixed_o  (fixed_w),
    .data_o   (dat_w),
    .corr_o   (corr_w),
    .uncorr_o (unc_w)
  );

  // R3
  clean_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_w == '0) |-> (!corr_w && !unc_w && fixed_w == rd_code));

  // R5
  miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unc_w |-> (fixed_w == rd_code && !corr_w));

  // R4
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_w |-> ($countones(fixed_w ^ rd_code) == 1));

  if (PIPE_STAGE) begin : g_pipe
    logic [DW-1:0] data_q, data_d;
    logic          corr_q, corr_d;
    logic          unc_q,  unc_d;

    always_comb begin
      data_d = data_q;
      corr_d = corr_q;
      unc_d  = unc_q;
      if (rd_en) begin
        data_d = dat_w;
        corr_d = corr_w;
        unc_d  = unc_w;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        corr_q <= 1'b0;
        unc_q  <= 1'b0;
      end else begin
        data_q <= data_d;
        corr_q <= corr_d;
        unc_q  <= unc_d;
      end
    end

    assign rd_data          = data_q;
    assign rd_corrected     = corr_q;
    assign rd_uncorrectable = unc_q;

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> ($stable(rd_data) && $stable(rd_corrected) && $stable(rd_uncorrectable)));
  end else begin : g_flow
    assign rd_data          = dat_w;
    assign rd_corrected     = corr_w;
    assign rd_uncorrectable = unc_w;
  end

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_corrected && rd_uncorrectable));
endmodule

// File: tb/tb_ecc_codec.sv
module tb_ecc_codec;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] wr_data;
  logic [NW-1:0] wr_code;
  logic          rd_en;
  logic [NW-1:0] rd_code;
  logic [DW-1:0] rd_data;
  logic          rd_corrected;
  logic          rd_uncorrectable;

  int checks = 0;
  int errors = 0;
  int detected = 0;
  int miscorr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_codec dut (
    .clk (clk), .rst_n (rst_n), .wr_data (wr_data), .wr_code (wr_code),
    .rd_en (rd_en), .rd_code (rd_code), .rd_data (rd_data),
    .rd_corrected (rd_corrected), .rd_uncorrectable (rd_uncorrectable)
  );

  // behavioural reference: builds the word position by position
  function automatic logic [NW-1:0] ref_encode(input logic [DW-1:0] d);
    logic [NW-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= NW; p++) begin
      if ((p & (p - 1)) != 0) begin
        w[p-1] = d[k];
        k++;
      end
    end
    for (int i = 0; i < 5; i++) begin
      int ones;
      ones = 0;
      for (int p = 1; p <= NW; p++)
        if (((p >> i) & 1) == 1 && w[p-1]) ones++;
      w[(1 << i) - 1] = ones[0];
    end
    return w;
  endfunction

  function automatic int ref_syn(input logic [NW-1:0] w);
    int s;
    s = 0;
    for (int p = 1; p <= NW; p++) if (w[p-1]) s = s ^ p;
    return s;
  endfunction

  function automatic logic [DW-1:0] ref_extract(input logic [NW-1:0] w);
    logic [DW-1:0] d;
    int k;
    k = 0;
    d = '0;
    for (int p = 1; p <= NW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p-1];
        k++;
      end
    end
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_encode(input logic [DW-1:0] d);
    logic [NW-1:0] e;
    @(negedge clk);
    wr_data = d;
    #1;
    e = ref_encode(d);
    check("R1 layout", 32'(wr_code), 32'(e));
    check("R2 zero syndrome", 32'(ref_syn(wr_code)), 32'd0);
  endtask

  // drives one read, returns the flags seen one clock later
  task automatic do_read(input logic [NW-1:0] w, input string req,
                         output logic c, output logic u);
    int s;
    logic [NW-1:0] f;
    @(negedge clk);
    rd_code = w;
    rd_en   = 1'b1;
    @(negedge clk);
    s = ref_syn(w);
    f = w;
    if (s >= 1 && s <= NW) f[s-1] = ~f[s-1];
    check(req, 32'(rd_data), 32'(ref_extract(f)));
    check(req, 32'(rd_corrected), 32'(s >= 1 && s <= NW));
    check(req, 32'(rd_uncorrectable), 32'(s > NW));
    check("R6 exclusive", 32'(rd_corrected & rd_uncorrectable), 32'd0);
    c = rd_corrected;
    u = rd_uncorrectable;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic c, u;
    logic [DW-1:0] pats [5];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
    pats[3] = 16'h0001; pats[4] = 16'h8000;
    rst_n   = 1'b0;
    wr_data = '0;
    rd_en   = 1'b0;
    rd_code = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset data", 32'(rd_data), 32'd0);
    check("R8 reset corr", 32'(rd_corrected), 32'd0);
    check("R8 reset unc", 32'(rd_uncorrectable), 32'd0);
    rst_n = 1'b1;

    // R1 / R2: encoder layout and parity, including single data bit walk
    foreach (pats[i]) do_encode(pats[i]);
    for (int k = 0; k < DW; k++) do_encode(DW'(1) << k);

    // R3: clean words
    foreach (pats[i]) begin
      do_read(ref_encode(pats[i]), "R3 clean", c, u);
      check("R3 no flag", 32'(c | u), 32'd0);
    end

    // R4: all single errors on several patterns
    foreach (pats[i]) begin
      for (int p = 1; p <= NW; p++) begin
        logic [NW-1:0] w;
        w = ref_encode(pats[i]);
        w[p-1] = ~w[p-1];
        do_read(w, "R4 single", c, u);
        check("R4 data restored", 32'(rd_data), 32'(pats[i]));
        check("R4 flag", 32'(c), 32'd1);
      end
    end

    // R7 / R5: all 210 double errors
    for (int a = 1; a <= NW; a++) begin
      for (int b = a + 1; b <= NW; b++) begin
        logic [NW-1:0] w;
        w = ref_encode(16'h3C96);
        w[a-1] = ~w[a-1];
        w[b-1] = ~w[b-1];
        do_read(w, ((a ^ b) > NW) ? "R5 out of range" : "R7 double", c, u);
        check("R7 never clean", 32'(c | u), 32'd1);
        if (u) detected++; else miscorr++;
      end
    end
    check("R7 pair count", 32'(detected + miscorr), 32'd210);
    $display("double errors detected: %0d of 210 (%0d.%0d%%), mis-corrected: %0d",
             detected, detected * 100 / 210, (detected * 1000 / 210) % 10, miscorr);

    // R8: hold while rd_en low
    do_read(ref_encode(16'h1234), "R8 load", c, u);
    @(negedge clk);
    rd_en   = 1'b0;
    rd_code = ref_encode(16'hBEEF) ^ 21'h100000;
    repeat (2) @(negedge clk);
    check("R8 hold data", 32'(rd_data), 32'h1234);
    check("R8 hold flag", 32'(rd_corrected), 32'd0);
    rd_en = 1'b1;
    @(negedge clk);
    check("R8 reload data", 32'(rd_data), 32'hBEEF);
    check("R8 reload flag", 32'(rd_corrected), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule